// File: doc/BRIEF.md
# Flash command write sequencer

This block stands between the system bus and a nonvolatile memory array and enforces the short register ritual that software must follow before any array operation may begin. Software first writes a data word to an address inside the array window. It then writes an operation code to the command register. Finally it writes a 1 to the buffer-empty bit of the status register, which launches the operation. Any other write that arrives while this ritual is in progress is treated as a violation. A violation aborts the partial ritual and raises an access-error flag.

Accepted operations are passed to the array through a start pulse together with an opcode, an address and a data word. The sequencer then waits for a done pulse from the array, which also returns a blank indication and a not-erased error. A one-entry buffer allows a chain of burst programs to be queued back to back. For each burst after the first, the sequencer supplies the next address itself. The completion flag and the interrupt are held off until every queued and active operation has retired.

Top module: `flash_seq`

## Requirements
- R1: After reset, buf_empty and cmd_done are 1, and acc_err, prot_viol, blank, irq and op_start are 0.
- R2: A launch is accepted only as follows: an array write (bus_sel 0), then a command write (bus_sel 1), then a status write (bus_sel 2) with bit 7 set. This produces one op_start pulse carrying the command code, the written address and the written data.
- R3: Each of the following is a violation that sets acc_err, abandons the partial sequence and starts no operation: a command write or a launch write with no sequence open, or a write other than the expected next step while a sequence is open.
- R4: The accepted codes are 0x05 erase verify, 0x20 program, 0x25 burst program, 0x40 sector erase and 0x41 mass erase. Code 0x75 (margin set) is accepted only while special_mode is 1. Any other code written as step two sets acc_err.
- R5: An array write that would open a sequence sets acc_err and starts nothing when acc_err or prot_viol is already set, or when buf_empty is 0.
- R6: Launching mass erase (0x41) while prot_any is 1 sets prot_viol and starts no operation.
- R7: A status write with bit 7 clear clears acc_err if bit 4 is 1 and clears prot_viol if bit 5 is 1. A flag whose bit is written as 0 keeps its value.
- R8: While a burst program is active, buf_empty returns to 1 once the burst moves out of the buffer. A burst launched behind an active burst uses the previous burst address plus one and ignores the address written.
- R9: cmd_done is 0 from a launch until all buffered and active operations are done. irq equals irq_en while cmd_done is 1 and is 0 otherwise.
- R10: blank clears when an erase verify is launched. It sets when that erase verify completes with op_blank asserted.
- R11: An operation that completes with op_err asserted sets acc_err. The array raises op_err when a program targets a word that is not all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 2 | Write target: 0 array, 1 command, 2 status, 3 reserved |
| bus_addr | input | AW | Array word address |
| bus_wdata | input | DW | Write data |
| prot_any | input | 1 | Some protection is enabled |
| special_mode | input | 1 | Allows the margin code |
| irq_en | input | 1 | Interrupt enable |
| op_done | input | 1 | Array finished the active operation |
| op_blank | input | 1 | Erase verify found the array erased (valid with op_done) |
| op_err | input | 1 | Program target was not erased (valid with op_done) |
| buf_empty | output | 1 | Command buffer free for a new sequence |
| cmd_done | output | 1 | No operation pending or active |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| blank | output | 1 | Result of the last erase verify |
| irq | output | 1 | Completion interrupt |
| op_start | output | 1 | One-cycle start pulse to the array |
| op_code | output | 8 | Opcode of the active operation |
| op_addr | output | AW | Address of the active operation |
| op_data | output | DW | Data of the active operation |

## Verification
The hardest case to reach is the second burst launch. It must finish its whole three-write ritual while the first burst is still inside the array. The bench gives the array model a program latency longer than the ritual, waits at the ports for buf_empty to rise again, and launches the second burst at once with a deliberately wrong address. The bench then checks that cmd_done stays low across the first done pulse and that the model received the incremented address.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          prot_any,
  input  logic          special_mode,
  input  logic          irq_en,
  input  logic          op_done,
  input  logic          op_blank,
  input  logic          op_err,
  output logic          buf_empty,
  output logic          cmd_done,
  output logic          acc_err,
  output logic          prot_viol,
  output logic          blank,
  output logic          irq,
  output logic          op_start,
  output logic [7:0]    op_code,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  localparam logic [7:0] C_EV = 8'h05, C_PG = 8'h20, C_BP = 8'h25;
  localparam logic [7:0] C_SE = 8'h40, C_ME = 8'h41, C_MG = 8'h75;
  localparam logic [1:0] S_IDLE = 2'd0, S_ADDR = 2'd1, S_CMD = 2'd2;

  logic [1:0]    seq;
  logic [AW-1:0] s_addr, p_addr, a_addr, b_next;
  logic [DW-1:0] s_data, p_data, a_data;
  logic [7:0]    s_cmd, p_cmd, a_cmd;
  logic          p_vld, a_vld, acc_q, pv_q, blank_q, start_q;

  wire       wr_arr  = bus_wr && bus_sel == 2'd0;
  wire       wr_cmd  = bus_wr && bus_sel == 2'd1;
  wire       wr_stat = bus_wr && bus_sel == 2'd2;
  wire [7:0] wcode   = bus_wdata[7:0];
  wire       code_ok = wcode == C_EV || wcode == C_PG || wcode == C_BP ||
                       wcode == C_SE || wcode == C_ME ||
                       (wcode == C_MG && special_mode);
  wire       chain   = a_vld && a_cmd == C_BP;
  wire [AW-1:0] b_base = (s_cmd == C_BP && chain) ? b_next : s_addr;

  assign buf_empty = !p_vld && !(a_vld && a_cmd != C_BP);
  assign cmd_done  = !p_vld && !a_vld;
  assign irq       = irq_en && cmd_done;
  assign acc_err   = acc_q;
  assign prot_viol = pv_q;
  assign blank     = blank_q;
  assign op_start  = start_q;
  assign op_code   = a_cmd;
  assign op_addr   = a_addr;
  assign op_data   = a_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= S_IDLE;
      s_addr <= '0; s_data <= '0; s_cmd <= '0;
      p_addr <= '0; p_data <= '0; p_cmd <= '0; p_vld <= 1'b0;
      a_addr <= '0; a_data <= '0; a_cmd <= '0; a_vld <= 1'b0;
      b_next <= '0;
      acc_q <= 1'b0; pv_q <= 1'b0; blank_q <= 1'b0; start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (seq)
        S_IDLE: begin
          if (wr_arr) begin
            if (!buf_empty || acc_q || pv_q) acc_q <= 1'b1;
            else begin
              s_addr <= bus_addr;
              s_data <= bus_wdata;
              seq    <= S_ADDR;
            end
          end else if (wr_cmd) begin
            acc_q <= 1'b1;
          end else if (wr_stat) begin
            if (bus_wdata[7]) acc_q <= 1'b1;
            else if (bus_wdata[4]) acc_q <= 1'b0;
            if (!bus_wdata[7] && bus_wdata[5]) pv_q <= 1'b0;
          end
        end
        S_ADDR: begin
          if (wr_cmd && code_ok) begin
            s_cmd <= wcode;
            seq   <= S_CMD;
          end else if (bus_wr) begin
            acc_q <= 1'b1;
            seq   <= S_IDLE;
          end
        end
        S_CMD: begin
          if (wr_stat && bus_wdata[7]) begin
            seq <= S_IDLE;
            if (s_cmd == C_ME && prot_any) pv_q <= 1'b1;
            else begin
              p_vld  <= 1'b1;
              p_cmd  <= s_cmd;
              p_data <= s_data;
              p_addr <= b_base;
              if (s_cmd == C_BP) b_next <= b_base + 1'b1;
              if (s_cmd == C_EV) blank_q <= 1'b0;
            end
          end else if (bus_wr) begin
            acc_q <= 1'b1;
            seq   <= S_IDLE;
          end
        end
        default: seq <= S_IDLE;
      endcase
      if (a_vld && op_done) begin
        a_vld <= 1'b0;
        if (op_err) acc_q <= 1'b1;
        if (a_cmd == C_EV) blank_q <= op_blank;
      end else if (!a_vld && p_vld) begin
        a_vld   <= 1'b1;
        a_cmd   <= p_cmd;
        a_addr  <= p_addr;
        a_data  <= p_data;
        p_vld   <= 1'b0;
        start_q <= 1'b1;
      end
    end
  end

  assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);
  assert_abort_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(acc_q) && !$past(op_done)) |-> seq == S_IDLE);
  assert_pv_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pv_q) |-> !p_vld);
  assert_done_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(op_done));
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!start_q && !p_vld));
endmodule

// File: tb/tb_flash_seq.sv
module tb_flash_seq;
  localparam int PROG_LAT = 8, ERASE_LAT = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_sel = '0;
  logic [7:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic prot_any = 1'b0, special_mode = 1'b0, irq_en = 1'b0;
  logic op_done = 1'b0, op_blank = 1'b0, op_err = 1'b0;
  logic buf_empty, cmd_done, acc_err, prot_viol, blank, irq, op_start;
  logic [7:0] op_code, op_addr;
  logic [15:0] op_data;
  int tests = 0, fails = 0, starts = 0, dones = 0, base = 0;
  logic [7:0] last_addr = '0, last_code = '0;

  always #4 clk = ~clk;

  flash_seq #(.AW(8), .DW(16)) dut (.*);

  logic [15:0] mem [256];
  logic busy = 1'b0, bl;
  int cnt = 0;
  logic [7:0] m_code = '0, m_addr = '0;
  logic [15:0] m_data = '0;
  initial for (int i = 0; i < 256; i++) mem[i] = 16'hffff;

  always @(posedge clk) begin
    op_done <= 1'b0; op_blank <= 1'b0; op_err <= 1'b0;
    if (op_start) begin
      busy <= 1'b1; m_code <= op_code; m_addr <= op_addr; m_data <= op_data;
      cnt <= (op_code == 8'h40 || op_code == 8'h41) ? ERASE_LAT : PROG_LAT;
      starts <= starts + 1; last_addr <= op_addr; last_code <= op_code;
    end else if (busy) begin
      if (cnt > 1) cnt <= cnt - 1;
      else begin
        busy <= 1'b0; op_done <= 1'b1; dones <= dones + 1;
        case (m_code)
          8'h20, 8'h25: if (mem[m_addr] != 16'hffff) op_err <= 1'b1; else mem[m_addr] = m_data;
          8'h40: for (int i = 0; i < 256; i++) if ((i >> 4) == int'(m_addr[7:4])) mem[i] = 16'hffff;
          8'h41: for (int i = 0; i < 256; i++) mem[i] = 16'hffff;
          8'h05: begin
            bl = 1'b1;
            for (int i = 0; i < 256; i++) if (mem[i] != 16'hffff) bl = 1'b0;
            op_blank <= bl;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic launch(input logic [7:0] c, input logic [7:0] a, input logic [15:0] d);
    wr(2'd0, a, d); wr(2'd1, 8'h00, {8'h00, c}); wr(2'd2, 8'h00, 16'h0080);
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (!cmd_done) @(negedge clk);
  endtask

  // rows: step1, step2, step3 (0 array, 1 command, 2 launch, 3 none), code, prot, special, exp acc, exp pv
  localparam logic [17:0] VEC [13] = '{
    {2'd0, 2'd1, 2'd2, 8'h20, 4'b0000},
    {2'd1, 2'd3, 2'd3, 8'h20, 4'b0010},
    {2'd0, 2'd0, 2'd3, 8'h20, 4'b0010},
    {2'd0, 2'd1, 2'd3, 8'h33, 4'b0010},
    {2'd0, 2'd1, 2'd3, 8'h75, 4'b0010},
    {2'd0, 2'd1, 2'd1, 8'h20, 4'b0010},
    {2'd2, 2'd3, 2'd3, 8'h20, 4'b0010},
    {2'd0, 2'd1, 2'd2, 8'h41, 4'b1001},
    {2'd0, 2'd1, 2'd2, 8'h05, 4'b0000},
    {2'd0, 2'd1, 2'd2, 8'h75, 4'b0100},
    {2'd0, 2'd2, 2'd3, 8'h20, 4'b0010},
    {2'd0, 2'd1, 2'd2, 8'h40, 4'b0000},
    {2'd0, 2'd1, 2'd0, 8'h20, 4'b0010}
  };
  localparam string TAGS [13] = '{"R2", "R3", "R3", "R4", "R4", "R3", "R3",
                                  "R6", "R2", "R4", "R3", "R2", "R3"};

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL R9: watchdog expired, got busy expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [17:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 buf_empty", buf_empty, 1); check("R1 cmd_done", cmd_done, 1);
    check("R1 acc_err", acc_err, 0);     check("R1 prot_viol", prot_viol, 0);
    check("R1 blank", blank, 0);         check("R1 irq", irq, 0);
    check("R1 op_start", op_start, 0);

    for (int r = 0; r < 13; r++) begin
      v = VEC[r];
      prot_any = v[3]; special_mode = v[2]; base = starts;
      for (int k = 0; k < 3; k++) begin
        case (v[17-2*k -: 2])
          2'd0: wr(2'd0, 8'h80 + 8'(r), 16'h1000 + 16'(r));
          2'd1: wr(2'd1, 8'h00, {8'h00, v[11:4]});
          2'd2: wr(2'd2, 8'h00, 16'h0080);
          default: ;
        endcase
      end
      wait_idle();
      check({TAGS[r], " vector acc_err"}, acc_err, v[1]);
      check({TAGS[r], " vector prot_viol"}, prot_viol, v[0]);
      check({TAGS[r], " vector starts"}, starts - base, (v[1] | v[0]) ? 0 : 1);
      prot_any = 1'b0; special_mode = 1'b0;
      wr(2'd2, 8'h00, 16'h0030);
    end

    // R11 cumulative program
    launch(8'h20, 8'h20, 16'h1234); wait_idle();
    check("R11 first program acc_err", acc_err, 0);
    launch(8'h20, 8'h20, 16'h0034); wait_idle();
    check("R11 reprogram acc_err", acc_err, 1);
    check("R11 word kept", mem[8'h20], 16'h1234);
    wr(2'd2, 8'h00, 16'h0010);

    // R6 / R7 protection and selective clear
    prot_any = 1'b1; base = starts;
    launch(8'h41, 8'h00, 16'h0000); wait_idle();
    check("R6 prot_viol", prot_viol, 1); check("R6 no start", starts - base, 0);
    prot_any = 1'b0;
    wr(2'd2, 8'h00, 16'h0010);
    check("R7 pv kept", prot_viol, 1);
    wr(2'd2, 8'h00, 16'h0020);
    check("R7 pv cleared", prot_viol, 0);

    // R10 blank
    launch(8'h41, 8'h00, 16'h0000); wait_idle();
    launch(8'h05, 8'h00, 16'h0000); wait_idle();
    check("R10 blank after erase", blank, 1);
    launch(8'h05, 8'h00, 16'h0000);
    check("R10 blank cleared at launch", blank, 0);
    wait_idle();
    check("R10 blank again", blank, 1);
    launch(8'h20, 8'h05, 16'h0055); wait_idle();
    launch(8'h05, 8'h00, 16'h0000); wait_idle();
    check("R10 not blank", blank, 0);

    // R8 / R9 burst chain
    launch(8'h41, 8'h00, 16'h0000); wait_idle();
    base = dones;
    launch(8'h25, 8'h30, 16'h00a1);
    while (!buf_empty) @(negedge clk);
    check("R8 buffer reopened while busy", cmd_done, 0);
    launch(8'h25, 8'h77, 16'h00a2);
    while (dones < base + 1) @(negedge clk);
    check("R9 cmd_done held after first burst", cmd_done, 0);
    wait_idle();
    check("R9 both bursts retired", dones - base, 2);
    check("R8 incremented address", last_addr, 8'h31);
    check("R8 second word", mem[8'h31], 16'h00a2);
    check("R8 written address ignored", mem[8'h77], 16'hffff);
    check("R8 first word", mem[8'h30], 16'h00a1);

    // R5 buffer full and error-held launch
    base = starts;
    launch(8'h20, 8'h40, 16'h0040);
    wr(2'd0, 8'h41, 16'h0041);
    wait_idle();
    check("R5 write while busy acc_err", acc_err, 1);
    check("R5 only one start", starts - base, 1);
    base = starts;
    launch(8'h20, 8'h42, 16'h0042); wait_idle();
    check("R5 no start with error set", starts - base, 0);
    check("R5 word untouched", mem[8'h42], 16'hffff);
    wr(2'd2, 8'h00, 16'h0010);
    check("R7 acc cleared", acc_err, 0);

    // R9 interrupt, R2 operation fields
    irq_en = 1'b1;
    @(negedge clk);
    check("R9 irq idle", irq, 1);
    launch(8'h20, 8'h50, 16'h5050);
    check("R9 irq busy", irq, 0);
    wait_idle();
    check("R9 irq done", irq, 1);
    check("R2 opcode", last_code, 8'h20);
    check("R2 address", last_addr, 8'h50);
    check("R2 data", mem[8'h50], 16'h5050);
    irq_en = 1'b0;
    @(negedge clk);
    check("R9 irq disabled", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule